// File: doc/BRIEF.md
# Hardwired Step-Counter Control Unit

This block is the sequencer of a single-bus processor whose control signals are produced by fixed logic rather than a stored microprogram. A binary step counter advances once per clock and is decoded into one-hot timing lines T1..Tn. The opcode held in the instruction register is decoded into one-hot instruction lines. An encoder forms each datapath control signal as an OR of products of timing lines and instruction lines.

Three instruction flows are wired in. A shared three-step fetch applies to every opcode. A seven-step add adds a memory operand addressed by R3 into R1. A five-step unconditional branch adds the offset field to the already incremented PC. Any other opcode ends right after fetch.

The counter waits while a step asserts the wait-for-memory signal and the memory has not yet answered. A step that asserts End returns the counter to T1 so that the next fetch begins. The datapath itself lies outside the block. Only its control lines leave the block.

Top module: `hw_step_ctrl`

## Requirements
- R1: While `rst_n` is low, the counter holds at its first step, so only timing line bit 0 (T1) is high. This is independent of `mfc` and `ir_op`.
- R2: Outside reset, exactly one timing line is high. The active line moves up one bit per clock unless the step stalls (R6) or ends (R7).
- R3: Steps T1 to T3 are the same for every opcode. T1 asserts pc_out, mar_in, mem_rd, sel_four, alu_add and z_in. T2 asserts z_out, pc_in, y_in and wait_mfc. T3 asserts mdr_out and ir_in.
- R4: When `ir_op` equals 4'h1 (add), the following steps apply. T4 asserts r3_out, mar_in and mem_rd. T5 asserts r1_out, y_in and wait_mfc. T6 asserts mdr_out, sel_y, alu_add and z_in. T7 asserts z_out, r1_in and end_step.
- R5: When `ir_op` equals 4'h2 (unconditional branch), the following steps apply. T4 asserts ofs_out, sel_y, alu_add and z_in. T5 asserts z_out, pc_in and end_step.
- R6: While wait_mfc is high and `mfc` is low, the step does not advance. It advances on the first clock at which `mfc` is high.
- R7: After a clock in which end_step is high, the active timing line is T1.
- R8: Any opcode other than 4'h1 and 4'h2 asserts end_step at T4 and no other control signal.
- R9: z_in is high only in T1 (any opcode), in T6 for the add and in T4 for the branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_op | input | OPW | Opcode field of the instruction register |
| mfc | input | 1 | Memory function completed |
| t_line | output | NSTEP | One-hot timing lines, bit 0 is T1 |
| pc_out | output | 1 | PC drives the bus |
| pc_in | output | 1 | PC loads from the bus |
| mar_in | output | 1 | Memory address register loads |
| mem_rd | output | 1 | Memory read request |
| sel_four | output | 1 | ALU operand mux selects constant 4 |
| sel_y | output | 1 | ALU operand mux selects Y |
| alu_add | output | 1 | ALU adds |
| z_in | output | 1 | Z loads the ALU result |
| z_out | output | 1 | Z drives the bus |
| y_in | output | 1 | Y loads from the bus |
| wait_mfc | output | 1 | Step waits for memory completion |
| mdr_out | output | 1 | Memory data register drives the bus |
| ir_in | output | 1 | Instruction register loads |
| r1_out | output | 1 | R1 drives the bus |
| r1_in | output | 1 | R1 loads from the bus |
| r3_out | output | 1 | R3 drives the bus |
| ofs_out | output | 1 | IR offset field drives the bus |
| end_step | output | 1 | Last step of the instruction |

## Verification
The bench builds the block with its defaults: eight timing lines, a 4-bit opcode, add at 4'h1 and branch at 4'h2. With these values all seven add steps fit below the top timing line, so every product term of the encoder is reached. The opcodes 4'h0 and 4'hF exercise the early-end path. Memory-wait stalls are placed in both T2 and T5, with both single-cycle and immediate replies, and one reset is applied in the middle of a stall.

// File: rtl/hw_step_ctrl.sv
module hw_step_ctrl #(
  parameter int NSTEP = 8,
  parameter int OPW = 4,
  parameter logic [OPW-1:0] OP_ADD = 4'h1,
  parameter logic [OPW-1:0] OP_BR = 4'h2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPW-1:0]   ir_op,
  input  logic             mfc,
  output logic [NSTEP-1:0] t_line,
  output logic             pc_out,
  output logic             pc_in,
  output logic             mar_in,
  output logic             mem_rd,
  output logic             sel_four,
  output logic             sel_y,
  output logic             alu_add,
  output logic             z_in,
  output logic             z_out,
  output logic             y_in,
  output logic             wait_mfc,
  output logic             mdr_out,
  output logic             ir_in,
  output logic             r1_out,
  output logic             r1_in,
  output logic             r3_out,
  output logic             ofs_out,
  output logic             end_step
);
  localparam int CW = $clog2(NSTEP);

  logic [CW-1:0] cnt;
  logic run;
  logic t1, t2, t3, t4, t5, t6, t7;
  logic i_add, i_br, i_unk;

  assign run = !(wait_mfc && !mfc);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        cnt <= '0;
    else if (end_step) cnt <= '0;
    else if (run)      cnt <= cnt + CW'(1);

  assign t_line = {{(NSTEP-1){1'b0}}, 1'b1} << cnt;
  assign {t7, t6, t5, t4, t3, t2, t1} = t_line[6:0];

  assign i_add = (ir_op == OP_ADD);
  assign i_br  = (ir_op == OP_BR);
  assign i_unk = !i_add && !i_br;

  assign pc_out   = t1;
  assign sel_four = t1;
  assign ir_in    = t3;
  assign mar_in   = t1 | (t4 & i_add);
  assign mem_rd   = t1 | (t4 & i_add);
  assign alu_add  = t1 | (t6 & i_add) | (t4 & i_br);
  assign z_in     = t1 | (t6 & i_add) | (t4 & i_br);
  assign z_out    = t2 | (t7 & i_add) | (t5 & i_br);
  assign pc_in    = t2 | (t5 & i_br);
  assign y_in     = t2 | (t5 & i_add);
  assign wait_mfc = t2 | (t5 & i_add);
  assign mdr_out  = t3 | (t6 & i_add);
  assign sel_y    = (t6 & i_add) | (t4 & i_br);
  assign r3_out   = t4 & i_add;
  assign r1_out   = t5 & i_add;
  assign r1_in    = t7 & i_add;
  assign ofs_out  = t4 & i_br;
  assign end_step = (t7 & i_add) | (t5 & i_br) | (t4 & i_unk);
endmodule

// File: rtl/hw_step_ctrl_chk.sv
module hw_step_ctrl_chk #(
  parameter int NSTEP = 8,
  parameter int OPW = 4,
  parameter logic [OPW-1:0] OP_ADD = 4'h1,
  parameter logic [OPW-1:0] OP_BR = 4'h2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [OPW-1:0]   ir_op,
  input logic             mfc,
  input logic [NSTEP-1:0] t_line,
  input logic             z_in,
  input logic             wait_mfc,
  input logic             r1_in,
  input logic             r3_out,
  input logic             ofs_out,
  input logic             end_step
);
  a_r1_reset_first: assert property (@(posedge clk)
    !rst_n |=> t_line == NSTEP'(1));

  a_r2_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(t_line) == 1);

  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!end_step && !(wait_mfc && !mfc) && !t_line[NSTEP-1]) |=> t_line == ($past(t_line) << 1));

  a_r3_fetch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (t_line[2:0] != 3'b000) |-> !(r1_in || r3_out || ofs_out || end_step));

  a_r6_hold_on_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_mfc && !mfc) |=> $stable(t_line));

  a_r7_back_to_first: assert property (@(posedge clk) disable iff (!rst_n)
    end_step |=> t_line[0]);

  a_r8_unknown_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (t_line[3] && ir_op != OP_ADD && ir_op != OP_BR) |-> end_step);

  a_r9_zin_slots: assert property (@(posedge clk) disable iff (!rst_n)
    z_in |-> (t_line[0] || (t_line[5] && ir_op == OP_ADD) || (t_line[3] && ir_op == OP_BR)));
endmodule

bind hw_step_ctrl hw_step_ctrl_chk #(
  .NSTEP(NSTEP), .OPW(OPW), .OP_ADD(OP_ADD), .OP_BR(OP_BR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ir_op(ir_op), .mfc(mfc), .t_line(t_line),
  .z_in(z_in), .wait_mfc(wait_mfc), .r1_in(r1_in), .r3_out(r3_out),
  .ofs_out(ofs_out), .end_step(end_step)
);

// File: tb/sim_hw_step_ctrl.sv
module sim_hw_step_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] ir_op = 4'h0;
  logic mfc = 1'b0;
  logic [7:0] t_line;
  logic pc_out, pc_in, mar_in, mem_rd, sel_four, sel_y, alu_add, z_in, z_out;
  logic y_in, wait_mfc, mdr_out, ir_in, r1_out, r1_in, r3_out, ofs_out, end_step;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hw_step_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ir_op(ir_op), .mfc(mfc), .t_line(t_line),
    .pc_out(pc_out), .pc_in(pc_in), .mar_in(mar_in), .mem_rd(mem_rd),
    .sel_four(sel_four), .sel_y(sel_y), .alu_add(alu_add), .z_in(z_in),
    .z_out(z_out), .y_in(y_in), .wait_mfc(wait_mfc), .mdr_out(mdr_out),
    .ir_in(ir_in), .r1_out(r1_out), .r1_in(r1_in), .r3_out(r3_out),
    .ofs_out(ofs_out), .end_step(end_step)
  );

  logic [17:0] cw;
  assign cw = {pc_out, pc_in, mar_in, mem_rd, sel_four, sel_y, alu_add, z_in, z_out,
               y_in, wait_mfc, mdr_out, ir_in, r1_out, r1_in, r3_out, ofs_out, end_step};

  localparam logic [17:0] PCO = 18'h1 << 17, PCI = 18'h1 << 16, MARI = 18'h1 << 15;
  localparam logic [17:0] RD = 18'h1 << 14, S4 = 18'h1 << 13, SY = 18'h1 << 12;
  localparam logic [17:0] ADDF = 18'h1 << 11, ZI = 18'h1 << 10, ZO = 18'h1 << 9;
  localparam logic [17:0] YI = 18'h1 << 8, WM = 18'h1 << 7, MDRO = 18'h1 << 6;
  localparam logic [17:0] IRI = 18'h1 << 5, R1O = 18'h1 << 4, R1I = 18'h1 << 3;
  localparam logic [17:0] R3O = 18'h1 << 2, OFO = 18'h1 << 1, ENDS = 18'h1;

  localparam logic [17:0] F1 = PCO | MARI | RD | S4 | ADDF | ZI;
  localparam logic [17:0] F2 = ZO | PCI | YI | WM;
  localparam logic [17:0] F3 = MDRO | IRI;
  localparam logic [17:0] A4 = R3O | MARI | RD;
  localparam logic [17:0] A5 = R1O | YI | WM;
  localparam logic [17:0] A6 = MDRO | SY | ADDF | ZI;
  localparam logic [17:0] A7 = ZO | R1I | ENDS;
  localparam logic [17:0] B4 = OFO | SY | ADDF | ZI;
  localparam logic [17:0] B5 = ZO | PCI | ENDS;

  localparam logic [3:0] OA = 4'h1, OB = 4'h2;
  localparam int NV = 20;
  // {opcode, mfc, expected timing lines, expected control word}
  localparam logic [30:0] VEC [NV] = '{
    {OB,   1'b0, 8'h01, F1},
    {OB,   1'b0, 8'h02, F2},
    {OB,   1'b1, 8'h02, F2},
    {OA,   1'b0, 8'h04, F3},
    {OA,   1'b0, 8'h08, A4},
    {OA,   1'b0, 8'h10, A5},
    {OA,   1'b0, 8'h10, A5},
    {OA,   1'b1, 8'h10, A5},
    {OA,   1'b0, 8'h20, A6},
    {OA,   1'b0, 8'h40, A7},
    {OA,   1'b1, 8'h01, F1},
    {OA,   1'b1, 8'h02, F2},
    {OB,   1'b0, 8'h04, F3},
    {OB,   1'b0, 8'h08, B4},
    {OB,   1'b0, 8'h10, B5},
    {4'hF, 1'b0, 8'h01, F1},
    {4'hF, 1'b1, 8'h02, F2},
    {4'h0, 1'b0, 8'h04, F3},
    {4'h0, 1'b0, 8'h08, ENDS},
    {OA,   1'b0, 8'h01, F1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic string cw_tag(input logic [3:0] op, input logic [7:0] t);
    if (t <= 8'h04) return "R3 fetch step";
    if (op == OA) return "R4 add step";
    if (op == OB) return "R5 branch step";
    return "R8 unknown opcode";
  endfunction

  function automatic string step_tag(input int i);
    if (i == 0) return "R2 first step after reset";
    if ((VEC[i-1][17:0] & ENDS) != 0) return "R7 return to T1";
    if ((VEC[i-1][17:0] & WM) != 0) return "R6 wait on mfc";
    return "R2 step advance";
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    mfc = 1'b1;
    ir_op = OA;
    #1;
    check("R1 timing lines in reset", 32'(t_line), 32'h01);
    check("R1 fetch word in reset", 32'(cw), 32'(F1));
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      ir_op = VEC[i][30:27];
      mfc = VEC[i][26];
      #1;
      check(step_tag(i), 32'(t_line), 32'(VEC[i][25:18]));
      check(cw_tag(VEC[i][30:27], VEC[i][25:18]), 32'(cw), 32'(VEC[i][17:0]));
      check("R9 z_in slot", 32'(z_in), 32'(VEC[i][10]));
      @(negedge clk);
    end
    // now in T2 of a new add, waiting on memory
    ir_op = OA;
    mfc = 1'b0;
    #1;
    check("R6 waiting in T2", 32'(t_line), 32'h02);
    rst_n = 1'b0;
    #1;
    check("R1 reset during wait", 32'(t_line), 32'h01);
    mfc = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check("R1 reset holds T1", 32'(t_line), 32'h01);
    check("R1 reset holds fetch word", 32'(cw), 32'(F1));
    rst_n = 1'b1;
    mfc = 1'b0;
    @(negedge clk);
    repeat (5) @(negedge clk);
    #1;
    check("R6 long wait in T2", 32'(t_line), 32'h02);
    check("R6 long wait word", 32'(cw), 32'(F2));
    mfc = 1'b1;
    @(negedge clk);
    #1;
    check("R6 advance on mfc", 32'(t_line), 32'h04);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule